// File: doc/BRIEF.md
# Static Memory Bank Controller with Page-Mode Timing

This block sits between a bus master's read request path and up to five external ROM, SRAM or flash banks that share a 64 MB address space. Each bank has its own configuration word: a start pointer and an end-plus-one pointer, both in 64 KB units, a full access time, a page size and a page access time. For each request the block decodes the address against every enabled window, selects a bank, asserts that bank's active-low chip select together with the output enable for the programmed number of cycles, and marks the final cycle with a data-valid pulse.

Page-mode devices get faster repeat reads. While a page is open, a read that lands in the same bank and in the same 4-, 8- or 16-word page as the previous read finishes in the shorter page time. A read that matches no window, or that hits a bank whose access time uses the reserved code, produces no chip select. Instead it raises a one-cycle error and closes any open page.

The controller is a four-state machine. ST_IDLE waits for a request. ST_FULL runs a full-length access. ST_PAGE runs an in-page access. ST_FAULT flags a decode failure for one cycle. The transitions are:
- accept-full: ST_IDLE to ST_FULL.
- accept-page: ST_IDLE to ST_PAGE.
- accept-miss: ST_IDLE to ST_FAULT.
- finish: ST_FULL or ST_PAGE back to ST_IDLE once the cycle count is used up.
- recover: ST_FAULT to ST_IDLE after one cycle.

Top module: `rom_bank_ctrl`

## Requirements
- R1: After reset the outputs are idle: ready_o=1, all cs_n_o=1, oe_n_o=1, dvalid_o=0, err_o=0. Only bank 0 is enabled after reset, with start 0x000, end-plus-one 0x010, 7-cycle access and no paging. Banks 1 to 4 are disabled until written.
- R2: Bank 0's data width after reset is taken from boot_width_i, held during reset (00 = 8 bit, 01 = 16 bit, 10 = 32 bit). During an access, acc_width_o shows the selected bank's width field.
- R3: A bank matches when its access field is nonzero and start <= addr_i[25:16] < end-plus-one. When several banks match, the lowest-numbered bank wins.
- R4: A request is accepted on a clock edge where req_i=1 and ready_o=1. From the next cycle, exactly one cs_n_o bit (the selected bank) and oe_n_o are low for N cycles. For a full access N is the access field plus 1 (001 = 2 cycles up to 110 = 7 cycles).
- R5: dvalid_o is high for one cycle: the last cycle of each access. ready_o is high only while idle, and it returns high in the cycle after dvalid_o.
- R6: A page hit uses the page time (tpa 00 = 5, 01 = 2, 10 = 3, 11 = 4 cycles). A page hit needs all of the following:
  - the page field is nonzero (01 = 4 words, 10 = 8 words, 11 = 16 words);
  - the previous accepted request went to the same bank;
  - addr_i bits from bit 4, 5 or 6 upward (for 4, 8 or 16 words) equal those of the previous request.
  A page field of 00 never gives a page hit.
- R7: The first access to a new page, or to a bank, uses the full access time.
- R8: A request that matches no bank, or whose selected bank has access code 111, asserts no chip select. err_o is high for exactly the one cycle after acceptance, ready_o returns in the following cycle, and the open page is closed.
- R9: A configuration write (cfg_we_i) loads cfg_data_i into the bank given by cfg_sel_i and closes the open page. The fields of cfg_data_i are:
  - page size, bits 1:0;
  - page time, bits 3:2;
  - access time, bits 6:4;
  - width, bits 8:7;
  - start pointer, bits 18:9;
  - end-plus-one pointer, bits 28:19.
- R10: A request presented while an access is in progress is ignored: after the access ends no further access or error follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_width_i | input | 2 | Boot data width for bank 0, sampled during reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Bank index for the configuration write |
| cfg_data_i | input | 29 | Configuration word |
| req_i | input | 1 | Read request |
| addr_i | input | 26 | Byte address of the request |
| ready_o | output | 1 | Controller idle, able to accept a request |
| cs_n_o | output | 5 | Active-low chip select per bank |
| oe_n_o | output | 1 | Active-low output enable |
| dvalid_o | output | 1 | Last cycle of an access, read data valid |
| err_o | output | 1 | One-cycle decode failure flag |
| acc_width_o | output | 2 | Data width of the bank being accessed |

## Verification
Reads are issued in several patterns:
- Repeated reads to an unpaged bank show that page logic stays out when the page field is zero.
- Walks through 4-, 8- and 16-word pages, with reads on both sides of each page boundary, separate the page time from the full time and reveal a wrong offset mask.
- Addresses on both sides of each start and end-plus-one pointer, together with two overlapping windows, separate an inclusive bound from an exclusive one and expose a wrong priority.
- A fault or a configuration write placed between two in-page reads shows whether the open page is dropped.
- A request raised in the middle of a busy access shows that it is ignored.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

    localparam int PTR_W = 10;
    localparam int CNT_W = 3;

    typedef struct packed {
        logic [PTR_W-1:0] nxt;
        logic [PTR_W-1:0] base;
        logic [1:0]       width;
        logic [2:0]       tacc;
        logic [1:0]       tpa;
        logic [1:0]       pmc;
    } bank_cfg_t;

    localparam int CFG_W = $bits(bank_cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FULL,
        ST_PAGE,
        ST_FAULT
    } state_t;

    localparam logic [2:0] TACC_OFF  = 3'b000;
    localparam logic [2:0] TACC_RSVD = 3'b111;
    localparam logic [2:0] BOOT_TACC = 3'b110;

    // Cycles of a full access minus one (counter load value)
    function automatic logic [CNT_W-1:0] full_load(input logic [2:0] tacc);
        return tacc;
    endfunction

    // Cycles of an in-page access minus one
    function automatic logic [CNT_W-1:0] page_load(input logic [1:0] tpa);
        return (tpa == 2'b00) ? CNT_W'(4) : CNT_W'(tpa);
    endfunction

    // Lowest address bit compared for a page hit
    function automatic logic [2:0] page_lsb(input logic [1:0] pmc);
        return {1'b0, pmc} + 3'd3;
    endfunction

endpackage

// File: rtl/rbc_cfg_regs.sv
module rbc_cfg_regs
    import rbc_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int SEL_W     = 3,
    parameter logic [PTR_W-1:0] BOOT_NEXT = 10'h010
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           boot_width_i,
    input  logic                 we_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [CFG_W-1:0]     wdata_i,
    output bank_cfg_t            cfg_o [NUM_BANKS]
);

    localparam bank_cfg_t BOOT_CFG = '{
        nxt:   BOOT_NEXT,
        base:  '0,
        width: 2'b00,
        tacc:  BOOT_TACC,
        tpa:   2'b00,
        pmc:   2'b00
    };

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        bank_cfg_t cfg_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                if (g == 0) begin
                    cfg_q       <= BOOT_CFG;
                    cfg_q.width <= boot_width_i;
                end else begin
                    cfg_q <= '0;
                end
            end else if (we_i && (sel_i == SEL_W'(g))) begin
                cfg_q <= bank_cfg_t'(wdata_i);
            end
        end

        assign cfg_o[g] = cfg_q;
    end

endmodule

// File: rtl/rbc_decode.sv
module rbc_decode
    import rbc_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int SEL_W     = 3,
    parameter int ADDR_W    = 26
) (
    input  bank_cfg_t         cfg_i [NUM_BANKS],
    input  logic [PTR_W-1:0]  ptr_i,
    output logic              hit_o,
    output logic              rsvd_o,
    output logic [SEL_W-1:0]  sel_o
);

    logic [NUM_BANKS-1:0] match;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_win
        assign match[g] = (cfg_i[g].tacc != TACC_OFF) &&
                          (ptr_i >= cfg_i[g].base) &&
                          (ptr_i <  cfg_i[g].nxt);
    end

    // Lowest index has priority: scan from the top so the last write wins
    always_comb begin
        hit_o = 1'b0;
        sel_o = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (match[b]) begin
                hit_o = 1'b1;
                sel_o = SEL_W'(b);
            end
        end
    end

    always_comb begin
        rsvd_o = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_o && (sel_o == SEL_W'(b)) && (cfg_i[b].tacc == TACC_RSVD)) begin
                rsvd_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rbc_page_trk.sv
module rbc_page_trk
    import rbc_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              fault_i,
    input  logic              cfg_we_i,
    input  logic [SEL_W-1:0]  bank_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        pmc_i,
    output logic              hit_o
);

    logic              open_q;
    logic [SEL_W-1:0]  bank_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] mask;

    assign mask  = {ADDR_W{1'b1}} << page_lsb(pmc_i);
    assign hit_o = open_q && (pmc_i != 2'b00) && (bank_q == bank_i) &&
                   (((addr_i ^ addr_q) & mask) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            bank_q <= '0;
            addr_q <= '0;
        end else if (cfg_we_i || fault_i) begin
            open_q <= 1'b0;
        end else if (accept_i) begin
            open_q <= (pmc_i != 2'b00);
            bank_q <= bank_i;
            addr_q <= addr_i;
        end
    end

    // R8
    fault_closes_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> !hit_o);

    // R9
    cfg_closes_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> !hit_o);

endmodule

// File: rtl/rom_bank_ctrl.sv
module rom_bank_ctrl
    import rbc_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 26,
    parameter logic [9:0] BOOT_NEXT = 10'h010
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            boot_width_i,
    input  logic                  cfg_we_i,
    input  logic [2:0]            cfg_sel_i,
    input  logic [28:0]           cfg_data_i,
    input  logic                  req_i,
    input  logic [ADDR_W-1:0]     addr_i,
    output logic                  ready_o,
    output logic [NUM_BANKS-1:0]  cs_n_o,
    output logic                  oe_n_o,
    output logic                  dvalid_o,
    output logic                  err_o,
    output logic [1:0]            acc_width_o
);

    localparam int SEL_W = 3;

    bank_cfg_t         cfg [NUM_BANKS];
    logic              dec_hit;
    logic              dec_rsvd;
    logic [SEL_W-1:0]  dec_sel;
    logic              pg_hit;
    logic              accept;
    logic              fault;
    bank_cfg_t         sel_cfg;

    state_t            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [SEL_W-1:0]  bank_q;
    logic [1:0]        width_q;
    logic              busy;

    rbc_cfg_regs #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W),
        .BOOT_NEXT (BOOT_NEXT)
    ) cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_width_i (boot_width_i),
        .we_i         (cfg_we_i),
        .sel_i        (cfg_sel_i),
        .wdata_i      (cfg_data_i),
        .cfg_o        (cfg)
    );

    rbc_decode #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W),
        .ADDR_W    (ADDR_W)
    ) dec_i (
        .cfg_i  (cfg),
        .ptr_i  (addr_i[ADDR_W-1 -: PTR_W]),
        .hit_o  (dec_hit),
        .rsvd_o (dec_rsvd),
        .sel_o  (dec_sel)
    );

    always_comb begin
        sel_cfg = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec_sel == SEL_W'(b)) sel_cfg = cfg[b];
        end
    end

    assign accept = (state_q == ST_IDLE) && req_i;
    assign fault  = accept && (!dec_hit || dec_rsvd);

    rbc_page_trk #(
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W)
    ) page_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .fault_i  (fault),
        .cfg_we_i (cfg_we_i),
        .bank_i   (dec_sel),
        .addr_i   (addr_i),
        .pmc_i    (sel_cfg.pmc),
        .hit_o    (pg_hit)
    );

    // Next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    if (!dec_hit || dec_rsvd) begin
                        state_d = ST_FAULT;
                    end else if (pg_hit) begin
                        state_d = ST_PAGE;
                        cnt_d   = page_load(sel_cfg.tpa);
                    end else begin
                        state_d = ST_FULL;
                        cnt_d   = full_load(sel_cfg.tacc);
                    end
                end
            end
            ST_FULL, ST_PAGE: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bank_q  <= '0;
            width_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept && !fault) begin
                bank_q  <= dec_sel;
                width_q <= sel_cfg.width;
            end
        end
    end

    // Outputs from registered state
    always_comb begin
        busy        = (state_q == ST_FULL) || (state_q == ST_PAGE);
        ready_o     = (state_q == ST_IDLE);
        err_o       = (state_q == ST_FAULT);
        oe_n_o      = !busy;
        dvalid_o    = busy && (cnt_q == '0);
        cs_n_o      = busy ? ~(NUM_BANKS'(1) << bank_q) : '1;
        acc_width_o = width_q;
    end

    // R4
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R4
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n_o && !dvalid_o) |=> ($stable(cs_n_o) && !oe_n_o));

    // R5
    dvalid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid_o |=> (ready_o && oe_n_o));

    // R8
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!err_o && ready_o));

    // R8
    err_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (&cs_n_o));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n_o && !dvalid_o) |=> !ready_o);

endmodule

// File: tb/rom_bank_ctrl_tb_top.sv
module rom_bank_ctrl_tb_top;

    localparam int NB = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  boot_width = 2'b01;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [28:0] cfg_data = '0;
    logic        req = 1'b0;
    logic [25:0] addr = '0;
    logic        ready;
    logic [NB-1:0] cs_n;
    logic        oe_n;
    logic        dvalid;
    logic        err;
    logic [1:0]  acc_width;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit chk_en = 1'b0;

    always #10 clk = ~clk;

    rom_bank_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_width_i (boot_width),
        .cfg_we_i     (cfg_we),
        .cfg_sel_i    (cfg_sel),
        .cfg_data_i   (cfg_data),
        .req_i        (req),
        .addr_i       (addr),
        .ready_o      (ready),
        .cs_n_o       (cs_n),
        .oe_n_o       (oe_n),
        .dvalid_o     (dvalid),
        .err_o        (err),
        .acc_width_o  (acc_width)
    );

    // ---------------- behavioural reference model ----------------
    int m_pmc[NB], m_tpa[NB], m_tacc[NB], m_wid[NB], m_base[NB], m_next[NB];
    int m_st;       // 0 idle, 1 busy, 2 fault
    int m_rem, m_bank;
    bit m_pg_ok;
    int m_pg_bank, m_pg_a;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_pmc[b] = 0; m_tpa[b] = 0; m_tacc[b] = 0;
                m_wid[b] = 0; m_base[b] = 0; m_next[b] = 0;
            end
            m_tacc[0] = 6; m_next[0] = 16; m_wid[0] = int'(boot_width);
            m_st = 0; m_rem = 0; m_bank = 0; m_pg_ok = 0; m_pg_bank = 0; m_pg_a = 0;
        end else begin
            if (m_st == 0) begin
                if (req) begin
                    int a, p, sel;
                    a = int'(addr);
                    p = a / 65536;
                    sel = -1;
                    for (int b = 0; b < NB; b++) begin
                        if (sel < 0 && m_tacc[b] != 0 && p >= m_base[b] && p < m_next[b]) sel = b;
                    end
                    if (sel < 0 || m_tacc[sel] == 7) begin
                        m_st = 2;
                        m_pg_ok = 0;
                    end else begin
                        int sh;
                        sh = m_pmc[sel] + 3;
                        if (m_pmc[sel] != 0 && m_pg_ok && m_pg_bank == sel &&
                            (a >> sh) == (m_pg_a >> sh))
                            m_rem = (m_tpa[sel] == 0) ? 5 : m_tpa[sel] + 1;
                        else
                            m_rem = m_tacc[sel] + 1;
                        m_pg_ok = (m_pmc[sel] != 0);
                        m_pg_bank = sel;
                        m_pg_a = a;
                        m_bank = sel;
                        m_st = 1;
                    end
                end
            end else if (m_st == 1) begin
                m_rem = m_rem - 1;
                if (m_rem == 0) m_st = 0;
            end else begin
                m_st = 0;
            end
            if (cfg_we) begin
                int s;
                s = int'(cfg_sel);
                if (s < NB) begin
                    m_pmc[s]  = int'(cfg_data[1:0]);
                    m_tpa[s]  = int'(cfg_data[3:2]);
                    m_tacc[s] = int'(cfg_data[6:4]);
                    m_wid[s]  = int'(cfg_data[8:7]);
                    m_base[s] = int'(cfg_data[18:9]);
                    m_next[s] = int'(cfg_data[28:19]);
                end
                m_pg_ok = 0;
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            logic [NB-1:0] e_cs;
            e_cs = (m_st == 1) ? ~(NB'(1) << m_bank) : '1;
            checks++;
            if (ready !== (m_st == 0)) begin
                errors++; $display("FAIL R5 ready: actual %0b expected %0b", ready, m_st == 0);
            end
            if (cs_n !== e_cs) begin
                errors++; $display("FAIL R4 cs_n: actual %b expected %b", cs_n, e_cs);
            end
            if (oe_n !== (m_st != 1)) begin
                errors++; $display("FAIL R4 oe_n: actual %0b expected %0b", oe_n, m_st != 1);
            end
            if (dvalid !== (m_st == 1 && m_rem == 1)) begin
                errors++; $display("FAIL R5 dvalid: actual %0b expected %0b", dvalid, m_st == 1 && m_rem == 1);
            end
            if (err !== (m_st == 2)) begin
                errors++; $display("FAIL R8 err: actual %0b expected %0b", err, m_st == 2);
            end
            if (m_st == 1 && acc_width !== 2'(m_wid[m_bank])) begin
                errors++; $display("FAIL R2 width: actual %0d expected %0d", acc_width, m_wid[m_bank]);
            end
        end
    end

    // ---------------- directed stimulus ----------------
    function automatic logic [28:0] mk(int pmc, int tpa, int tacc, int wid, int base, int nxt);
        return {10'(nxt), 10'(base), 2'(wid), 3'(tacc), 2'(tpa), 2'(pmc)};
    endfunction

    task automatic cfg_write(int bank, logic [28:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(bank); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // exp_bank < 0 means a decode fault is expected
    task automatic rd(int a, int exp_n, int exp_bank, string tag);
        int n;
        bit e;
        logic [NB-1:0] seen;
        @(negedge clk);
        req = 1'b1; addr = 26'(a);
        @(negedge clk);
        req = 1'b0;
        n = 0; e = 0; seen = '1;
        while (!ready) begin
            if (!(&cs_n)) begin n++; seen = cs_n; end
            if (err) e = 1;
            @(negedge clk);
        end
        checks++;
        if (exp_bank < 0) begin
            if (!e || n != 0) begin
                errors++;
                $display("FAIL %s addr %h: actual err=%0b cycles=%0d expected err=1 cycles=0", tag, a, e, n);
            end
        end else if (n != exp_n || seen !== ~(NB'(1) << exp_bank) || e) begin
            errors++;
            $display("FAIL %s addr %h: actual cycles=%0d cs=%b err=%0b expected cycles=%0d cs=%b err=0",
                     tag, a, n, seen, e, exp_n, ~(NB'(1) << exp_bank));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;  // R1 reset state
        if (ready !== 1'b1 || cs_n !== '1 || oe_n !== 1'b1 || dvalid !== 1'b0 || err !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual ready=%0b cs=%b oe=%0b dv=%0b err=%0b expected 1 11111 1 0 0",
                     ready, cs_n, oe_n, dvalid, err);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk_en = 1'b1;

        rd(32'h0000100, 7, 0, "R1 boot bank");
        rd(32'h0000104, 7, 0, "R6 no paging");
        rd(32'h00FFFFC, 7, 0, "R3 last bank0 word");
        rd(32'h0100000, 0, -1, "R3 end bound exclusive");
        rd(32'h0200000, 0, -1, "R1 bank1 disabled");

        cfg_write(1, mk(1, 1, 3, 2, 32'h020, 32'h040));
        rd(32'h0200000, 4, 1, "R7 first in page");
        rd(32'h0200008, 2, 1, "R6 4-word hit");
        rd(32'h020000C, 2, 1, "R6 4-word hit");
        rd(32'h0200010, 4, 1, "R7 new 4-word page");

        cfg_write(2, mk(0, 0, 1, 0, 32'h030, 32'h050));
        rd(32'h0300000, 4, 1, "R3 lowest bank wins");
        rd(32'h0400000, 2, 2, "R3 bank2 at bank1 end");
        rd(32'h04FFFFC, 2, 2, "R3 bank2 top");
        rd(32'h0500000, 0, -1, "R8 miss");

        cfg_write(3, mk(0, 0, 7, 0, 32'h060, 32'h061));
        rd(32'h0600000, 0, -1, "R8 reserved access");

        cfg_write(4, mk(3, 0, 6, 1, 32'h100, 32'h101));
        rd(32'h1000000, 7, 4, "R7 first 16-word");
        rd(32'h100003C, 5, 4, "R6 16-word hit");
        rd(32'h1000040, 7, 4, "R7 16-word boundary");
        rd(32'h1000044, 5, 4, "R6 16-word hit");
        rd(32'h0500000, 0, -1, "R8 miss");
        rd(32'h1000048, 7, 4, "R8 fault closes page");
        rd(32'h100004C, 5, 4, "R6 reopened page");
        cfg_write(2, mk(0, 0, 1, 0, 32'h030, 32'h050));
        rd(32'h1000050, 7, 4, "R9 write closes page");

        cfg_write(1, mk(2, 2, 3, 2, 32'h020, 32'h040));
        rd(32'h0200000, 4, 1, "R9 new fields");
        rd(32'h020001C, 3, 1, "R6 8-word hit");
        rd(32'h0200020, 4, 1, "R7 8-word boundary");

        // R10: request during a busy access is dropped
        @(negedge clk);
        req = 1'b1; addr = 26'h0000200;
        @(negedge clk);
        req = 1'b0;
        repeat (2) @(negedge clk);
        req = 1'b1; addr = 26'h0200000;
        @(negedge clk);
        req = 1'b0;
        while (!ready) @(negedge clk);
        repeat (2) begin
            checks++;
            if (!ready || cs_n !== '1 || !oe_n || err) begin
                errors++;
                $display("FAIL R10 ignored request: actual ready=%0b cs=%b err=%0b expected 1 11111 0",
                         ready, cs_n, err);
            end
            @(negedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule